// File: doc/BRIEF.md
# Smart fault shutdown sequencer

This block decides when the two gate outputs of a half-bridge driver may follow their commands. One pin serves two purposes. It is an active-low shutdown input, and it is also an open-drain fault output. An external RC timer hangs on that pin. The block receives three inputs, all already digitized:

- a trip from the fault comparator;
- a flag that the pin voltage is below its low input threshold;
- a flag that the pin voltage is above its high input threshold.

From these it drives three outputs: a gate-disable line, the enable of the pull-down transistor on the pin, and a fault-active flag.

A comparator trip cuts the gates at once, without waiting for the pin voltage to fall. The pull-down then discharges the pin capacitor. The block releases the pull-down once the pin reads below the low threshold, so the external pull-up can recharge the capacitor. The gates come back only when the pin rises above the high threshold. The RC network therefore sets how long the bridge stays off, but it adds nothing to the reaction time.

When no fault is present, an external controller may pull the pin low itself, for example with a PWM chopping signal. The block follows that level through the pin's hysteresis and does not latch it. Comparator trips are masked while the low-side supply is in undervoltage.

All inputs pass through a two-flop synchronizer, and the flops are clocked on `clk`. Because the block has no data stream, every port is a plain level signal with no handshake.

Top module: `fault_shutdown_seq`

## Requirements
- R1: During and after reset, and before the synchronized pin has read above its high threshold, `gate_off_o`=1, `od_pull_o`=0 and `fault_o`=0.
- R2: A trip on `trip_i` with `uv_i` low sets `gate_off_o` exactly 2 clock edges after `trip_i` rises, while both pin threshold inputs are unchanged.
- R3: The clock edge after the trip is seen, `od_pull_o` and `fault_o` go to 1. `od_pull_o` stays 1 for as long as `pin_below_lo_i` stays 0, even after `trip_i` returns low.
- R4: `od_pull_o` returns to 0 on the third clock edge after `pin_below_lo_i` rises. `gate_off_o` stays 1.
- R5: After a fault, `gate_off_o` stays 1 until `pin_above_hi_i` rises. It returns to 0 on the third edge after that rise.
- R6: A pin pulled low from outside with no trip sets `gate_off_o` on the third edge after `pin_below_lo_i` rises, and leaves `od_pull_o` and `fault_o` at 0. It is not latched: the third edge after `pin_above_hi_i` rises clears `gate_off_o` again, cycle after cycle.
- R7: While the synchronized `uv_i` is 1, a trip has no effect on `gate_off_o`, `od_pull_o` or `fault_o`.
- R8: A trip that arrives while the pin is recharging (pull-down released, pin not yet above the high threshold) turns `od_pull_o` back on on the third edge after `trip_i` rises.
- R9: `fault_o` is 1 from the edge after a trip is seen until the edge on which the synchronized high-threshold flag returns the sequencer to idle.
- R10: A trip reaches `gate_off_o` one clock earlier than a pin shutdown does: 2 edges against 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trip_i | input | 1 | Fault comparator trip, asynchronous |
| uv_i | input | 1 | Low-side supply undervoltage, asynchronous |
| pin_below_lo_i | input | 1 | Shared pin voltage below low input threshold |
| pin_above_hi_i | input | 1 | Shared pin voltage above high input threshold |
| gate_off_o | output | 1 | 1 forces both gate outputs low |
| od_pull_o | output | 1 | Enable of the open-drain pull-down on the pin |
| fault_o | output | 1 | Fault sequence in progress |

## Verification
The in-line assertions check several relations on every cycle:

- the pull-down and the fault flag both imply a disabled gate;
- the pull-down is held while the pin has not reached the low threshold;
- the pull-down is off during recharge;
- undervoltage keeps the idle state;
- a rising fault flag is always preceded by a disabled gate.

Some properties span several inputs and only the directed scenarios can show them:

- the exact edge counts of the trip path against the pin path;
- release at the low threshold and resume at the high threshold;
- the unlatched PWM behaviour of an external shutdown;
- re-entry into the hold state from recharge.

// File: rtl/fss_pkg.sv
package fss_pkg;
  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_TRIP_HOLD = 2'd1,
    ST_RECHARGE  = 2'd2
  } fss_state_e;

  localparam int unsigned NUM_ASYNC_INPUTS = 4;
  localparam int unsigned IDX_TRIP = 0;
  localparam int unsigned IDX_UV   = 1;
  localparam int unsigned IDX_LO   = 2;
  localparam int unsigned IDX_HI   = 3;
endpackage

// File: rtl/fss_sync.sv
module fss_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= '0;
          else        chain_q[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= '0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/fss_level_track.sv
module fss_level_track (
  input  logic clk,
  input  logic rst_n,
  input  logic below_lo_s_i,
  input  logic above_hi_s_i,
  output logic pin_high_o
);
  // Hysteresis on the shared pin: the low crossing wins if both are seen.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            pin_high_o <= 1'b0;
    else if (below_lo_s_i) pin_high_o <= 1'b0;
    else if (above_hi_s_i) pin_high_o <= 1'b1;
  end

  // R6
  lo_clears_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    below_lo_s_i |=> !pin_high_o);
endmodule

// File: rtl/fss_ctrl.sv
module fss_ctrl
  import fss_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic trip_s_i,
  input  logic uv_s_i,
  input  logic below_lo_s_i,
  input  logic above_hi_s_i,
  output logic trip_live_o,
  output logic in_fault_o,
  output logic od_pull_o
);
  fss_state_e state_q, state_d;

  assign trip_live_o = trip_s_i && !uv_s_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (trip_live_o) state_d = ST_TRIP_HOLD;
      ST_TRIP_HOLD: if (below_lo_s_i) state_d = ST_RECHARGE;
      ST_RECHARGE: begin
        if (trip_live_o)       state_d = ST_TRIP_HOLD;
        else if (above_hi_s_i) state_d = ST_IDLE;
      end
      default:                 state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign in_fault_o = (state_q != ST_IDLE);
  assign od_pull_o  = (state_q == ST_TRIP_HOLD);

  // R3
  hold_until_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (od_pull_o && !below_lo_s_i) |=> od_pull_o);
  // R4
  recharge_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RECHARGE) |-> !od_pull_o);
  // R7
  uv_masks_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_IDLE) && uv_s_i) |=> (state_q == ST_IDLE));
  // R8
  retrip_reenters_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_RECHARGE) && trip_s_i && !uv_s_i) |=> od_pull_o);
endmodule

// File: rtl/fault_shutdown_seq.sv
module fault_shutdown_seq
  import fss_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_i,
  input  logic uv_i,
  input  logic pin_below_lo_i,
  input  logic pin_above_hi_i,
  output logic gate_off_o,
  output logic od_pull_o,
  output logic fault_o
);
  logic [NUM_ASYNC_INPUTS-1:0] raw_in, sync_in;
  logic trip_live, in_fault, pin_high;

  always_comb begin
    raw_in           = '0;
    raw_in[IDX_TRIP] = trip_i;
    raw_in[IDX_UV]   = uv_i;
    raw_in[IDX_LO]   = pin_below_lo_i;
    raw_in[IDX_HI]   = pin_above_hi_i;
  end

  fss_sync #(.WIDTH(NUM_ASYNC_INPUTS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw_in), .q_o(sync_in)
  );

  fss_level_track u_level (
    .clk(clk), .rst_n(rst_n),
    .below_lo_s_i(sync_in[IDX_LO]), .above_hi_s_i(sync_in[IDX_HI]),
    .pin_high_o(pin_high)
  );

  fss_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .trip_s_i(sync_in[IDX_TRIP]), .uv_s_i(sync_in[IDX_UV]),
    .below_lo_s_i(sync_in[IDX_LO]), .above_hi_s_i(sync_in[IDX_HI]),
    .trip_live_o(trip_live), .in_fault_o(in_fault), .od_pull_o(od_pull_o)
  );

  // Fast path: a live trip disables the gates in the cycle it is seen.
  assign gate_off_o = trip_live || in_fault || !pin_high;
  assign fault_o    = in_fault;

  // R3
  pull_implies_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    od_pull_o |-> gate_off_o);
  // R5
  fault_implies_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> gate_off_o);
  // R2
  off_before_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_o) |-> $past(gate_off_o));
  // R1
  always_comb begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!od_pull_o && !fault_o && gate_off_o);
    end
  end
endmodule

// File: tb/test_fault_shutdown_seq.sv
module test_fault_shutdown_seq;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG_CYCLES = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trip_i = 1'b0, uv_i = 1'b0, lo_i = 1'b0, hi_i = 1'b1;
  logic gate_off_o, od_pull_o, fault_o;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_shutdown_seq i_fault_shutdown_seq (
    .clk(clk), .rst_n(rst_n), .trip_i(trip_i), .uv_i(uv_i),
    .pin_below_lo_i(lo_i), .pin_above_hi_i(hi_i),
    .gate_off_o(gate_off_o), .od_pull_o(od_pull_o), .fault_o(fault_o)
  );

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", what, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic drive_at_negedge();
    @(negedge clk);
  endtask

  task automatic t_reset();
    #1;
    chk(gate_off_o, 1'b1, "R1 gate_off in reset");
    chk(od_pull_o, 1'b0, "R1 od_pull in reset");
    chk(fault_o, 1'b0, "R1 fault in reset");
    drive_at_negedge(); rst_n = 1'b1;
    edges(2);
    chk(gate_off_o, 1'b1, "R1 gate_off before high level seen");
    edges(2);
    chk(gate_off_o, 1'b0, "R1 gates released after high level");
  endtask

  task automatic t_trip_cycle();
    drive_at_negedge(); trip_i = 1'b1;
    edges(1);
    chk(gate_off_o, 1'b0, "R2 not yet off after one edge");
    edges(1);
    chk(gate_off_o, 1'b1, "R2/R10 off after two edges, pin untouched");
    chk(od_pull_o, 1'b0, "R3 pull not yet on");
    edges(1);
    chk(od_pull_o, 1'b1, "R3 pull on");
    chk(fault_o, 1'b1, "R9 fault on");
    drive_at_negedge(); trip_i = 1'b0; hi_i = 1'b0;
    edges(6);
    chk(od_pull_o, 1'b1, "R3 pull held above low threshold");
    chk(gate_off_o, 1'b1, "R3 gates off while held");
    drive_at_negedge(); lo_i = 1'b1;
    edges(2);
    chk(od_pull_o, 1'b1, "R4 pull still on before sync");
    edges(1);
    chk(od_pull_o, 1'b0, "R4 pull released at low threshold");
    chk(gate_off_o, 1'b1, "R4 gates stay off");
    drive_at_negedge(); lo_i = 1'b0;
    edges(6);
    chk(gate_off_o, 1'b1, "R5 off between thresholds");
    chk(fault_o, 1'b1, "R9 fault during recharge");
    drive_at_negedge(); hi_i = 1'b1;
    edges(2);
    chk(gate_off_o, 1'b1, "R5 off until high level synced");
    edges(1);
    chk(gate_off_o, 1'b0, "R5 resume at high threshold");
    chk(fault_o, 1'b0, "R9 fault cleared at high threshold");
  endtask

  task automatic t_external_pwm();
    for (int k = 0; k < 3; k++) begin
      drive_at_negedge(); hi_i = 1'b0; lo_i = 1'b1;
      edges(2);
      chk(gate_off_o, 1'b0, "R10 pin path slower than trip path");
      edges(1);
      chk(gate_off_o, 1'b1, "R6 external low disables");
      chk(od_pull_o, 1'b0, "R6 no pull on external low");
      chk(fault_o, 1'b0, "R6 no fault on external low");
      drive_at_negedge(); lo_i = 1'b0; hi_i = 1'b1;
      edges(3);
      chk(gate_off_o, 1'b0, "R6 not latched, gates resume");
    end
  endtask

  task automatic t_uv_mask();
    drive_at_negedge(); uv_i = 1'b1;
    edges(3);
    drive_at_negedge(); trip_i = 1'b1;
    edges(4);
    chk(gate_off_o, 1'b0, "R7 trip ignored in undervoltage");
    chk(od_pull_o, 1'b0, "R7 no pull in undervoltage");
    chk(fault_o, 1'b0, "R7 no fault in undervoltage");
    drive_at_negedge(); trip_i = 1'b0;
    edges(3);
    drive_at_negedge(); uv_i = 1'b0;
    edges(3);
    chk(gate_off_o, 1'b0, "R7 gates still on after undervoltage");
  endtask

  task automatic t_retrip();
    drive_at_negedge(); trip_i = 1'b1;
    edges(3);
    drive_at_negedge(); trip_i = 1'b0; hi_i = 1'b0; lo_i = 1'b1;
    edges(4);
    chk(od_pull_o, 1'b0, "R8 in recharge before retrip");
    drive_at_negedge(); lo_i = 1'b0; trip_i = 1'b1;
    edges(3);
    chk(od_pull_o, 1'b1, "R8 retrip turns pull back on");
    chk(fault_o, 1'b1, "R9 fault during retrip");
    drive_at_negedge(); trip_i = 1'b0; lo_i = 1'b1;
    edges(4);
    chk(od_pull_o, 1'b0, "R8 released again");
    drive_at_negedge(); lo_i = 1'b0; hi_i = 1'b1;
    edges(3);
    chk(gate_off_o, 1'b0, "R5 resume after retrip");
  endtask

  initial begin
    t_reset();
    t_trip_cycle();
    t_external_pwm();
    t_uv_mask();
    t_retrip();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule